// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the host-facing side of a timekeeping register set. An external host reaches it over three wires: an active-high transfer enable, a serial clock and one data line that turns around between host and slave. All three are brought into a faster system clock through synchronizers. Every transfer opens with an 8-bit command byte. The command picks the clock-register space or the scratch RAM space, a 5-bit location and a direction. One data byte then follows, or a run of bytes when the location field is all ones (burst).

The block does not hold the timekeeping registers or the RAM. It emits registered write strobes, an address and write data toward an external clock register file (locations 0 to 6) and a 31-byte scratch RAM (locations 0 to 30). Both return read data combinationally on the address. The block itself holds two registers. One is a control register at clock location 7, whose top bit is a write-protect flag. The other is a charger-select register at clock location 8. Its upper nibble turns the charger enable output on for exactly one pattern.

The serial clock and enable must each hold a level for at least 8 system clock cycles, so that every serial edge is seen as a separate event.

Top module: `triwire_slave`

## Requirements
- R1: After reset the data output enable is low, the write-protect flag is 0, the charger register is 0x00 (charger off), and no write strobe is issued.
- R2: The command byte is shifted in LSB first on rising serial clock edges. Bit 0 selects write (0) or read (1), bits 5:1 give the location, bit 6 selects clock space (0) or RAM (1), and bit 7 must be 1 for writes. Data bytes are also LSB first.
- R3: A single-byte write issues exactly one strobe, either `clk_wr_o` or `ram_wr_o`, carrying the addressed location and the received byte, after the eighth data rising edge. The two strobes are never high together.
- R4: A write command whose bit 7 is 0 changes nothing: no strobe, and no internal register update.
- R5: A single-byte read drives data bit 0 after the first falling edge following the last command bit, then one bit per falling edge, LSB first. Further clock cycles repeat the same byte while the enable stays high. Extra clock cycles after a single-byte write are ignored.
- R6: A clock-space burst write (command 0xBE) stores bytes for locations 0 to 7. Nothing is committed until the eighth byte arrives. Then locations 0 to 7 are written in ascending order, and the control register is committed last.
- R7: A RAM burst write (command 0xFE) commits each byte to consecutive RAM locations starting at 0 as soon as that byte is complete.
- R8: A burst read (command 0xBF or 0xFF) returns consecutive locations starting at 0. The location advances at each byte boundary and stays at 31.
- R9: The charger register reads back all 8 bits. `trickle_en_o` is high only when bits 7:4 equal 1010.
- R10: Control register bit 7 is write protect. While it is 1, writes to every other clock register, to the charger register and to RAM are discarded. The control register stays writable, and its bits 6:0 always read 0.
- R11: Clock locations 9 to 31 and RAM location 31 read 0x00, and writes to them issue no strobe.
- R12: Enable low ends a transfer at once. It drops the output enable without waiting for the synchronizer, discards a partly received byte, and lets the next transfer start with a fresh command.
- R13: The data line output enable falls after every rising serial clock edge, so the host can drive on that half cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_i | input | 1 | Serial transfer enable, active high, asynchronous |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| sdio_i | input | 1 | Serial data from the host |
| sdio_o | output | 1 | Serial data toward the host |
| sdio_oe | output | 1 | Output enable for the data line |
| reg_addr_o | output | 5 | Location presented to the register file and RAM |
| reg_wdata_o | output | 8 | Write data accompanying a strobe |
| clk_wr_o | output | 1 | One-cycle write strobe to the clock register file |
| ram_wr_o | output | 1 | One-cycle write strobe to the scratch RAM |
| clk_rdata_i | input | 8 | Clock register read data for `reg_addr_o` |
| ram_rdata_i | input | 8 | RAM read data for `reg_addr_o` |
| wp_o | output | 1 | Current write-protect flag |
| trickle_en_o | output | 1 | Charger enable decoded from the charger register |

## Verification
A serial edge takes about three system cycles to cross the synchronizer and edge detector. A write strobe follows the eighth data rising edge by two more cycles, and a clock burst commit runs for eight cycles after that. The bench therefore checks strobe counts and the protect and charger outputs only after the enable has been low for three serial half periods. It samples read bits 10 ns before each rising edge, and the output enable 30 ns after it. The write strobes are predicted in a queue by the driver and compared in order as they appear. A strobe that arrives too early, too late or out of order shows up as a count or ordering mismatch.

// File: rtl/tw_pkg.sv
// Shared types and constants for the three-wire serial slave.
// Assumes an 8-bit data path and a 5-bit location field.
package tw_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] LOC_CTRL    = 5'd7;   // control register
    localparam logic [ADDR_W-1:0] LOC_CHARGE  = 5'd8;   // charger select register
    localparam logic [ADDR_W-1:0] LOC_BURST   = 5'd31;  // burst code / empty slot

    typedef enum logic [1:0] {
        PH_CMD,
        PH_WDATA,
        PH_RDATA,
        PH_DONE
    } tw_phase_e;

    typedef struct packed {
        logic              allow;  // command bit 7
        logic              ram;    // 1 = RAM space
        logic              burst;  // burst transfer
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } tw_wreq_t;
endpackage

// File: rtl/tw_sync.sv
// Multi-bit level synchronizer for asynchronous host pins.
// Assumes each bit is independent; no bus coherency is implied.
module tw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    // Shift the raw pins through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], async_i};
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/tw_serial_fsm.sv
// Serial protocol engine: shifts the command and data in, sequences
// locations, fetches read bytes and drives the data line bit by bit.
// Assumes serial edges arrive as single-cycle pulses at least
// LOAD_WAIT+2 system cycles apart.
module tw_serial_fsm
    import tw_pkg::*;
#(
    parameter int LOAD_WAIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_s,
    input  logic              sdi_s,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_ram,
    output tw_wreq_t          wreq,
    output logic              wreq_valid,
    output logic              sdo_q,
    output logic              oe_q
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam int CNT_W = $clog2(LOAD_WAIT + 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOAD_WAIT);

    tw_phase_e         phase_q;
    logic [BIT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg, tx_q;
    logic [CNT_W-1:0]  load_cnt;
    logic              allow_q, burst_q;
    logic [DATA_W-1:0] shift_nxt;
    logic [ADDR_W-1:0] addr_adv;

    // Next shift-register value and the saturating burst location step.
    always_comb begin
        shift_nxt = {sdi_s, shreg[DATA_W-1:1]};
        addr_adv  = (cur_addr == LOC_BURST) ? cur_addr : cur_addr + 1'b1;
    end

    // Protocol sequencing on synchronized serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_CMD;
            bit_cnt    <= '0;
            shreg      <= '0;
            tx_q       <= '0;
            load_cnt   <= '0;
            allow_q    <= 1'b0;
            burst_q    <= 1'b0;
            cur_addr   <= '0;
            cur_ram    <= 1'b0;
            wreq       <= '0;
            wreq_valid <= 1'b0;
            sdo_q      <= 1'b0;
            oe_q       <= 1'b0;
        end else begin
            wreq_valid <= 1'b0;
            if (load_cnt != '0) begin
                load_cnt <= load_cnt - 1'b1;
                if (load_cnt == CNT_W'(1)) tx_q <= rd_data;
            end
            if (!ce_s) begin
                phase_q <= PH_CMD;
                bit_cnt <= '0;
                oe_q    <= 1'b0;
            end else if (sclk_rise) begin
                oe_q    <= 1'b0;
                bit_cnt <= bit_cnt + 1'b1;
                case (phase_q)
                    PH_CMD: begin
                        shreg <= shift_nxt;
                        if (bit_cnt == BIT_LAST) begin
                            allow_q  <= shift_nxt[7];
                            cur_ram  <= shift_nxt[6];
                            burst_q  <= (shift_nxt[5:1] == LOC_BURST);
                            cur_addr <= (shift_nxt[5:1] == LOC_BURST) ? '0 : shift_nxt[5:1];
                            if (shift_nxt[0]) begin
                                phase_q  <= PH_RDATA;
                                load_cnt <= CNT_LOAD;
                            end else begin
                                phase_q  <= PH_WDATA;
                            end
                        end
                    end
                    PH_WDATA: begin
                        shreg <= shift_nxt;
                        if (bit_cnt == BIT_LAST) begin
                            wreq_valid <= 1'b1;
                            wreq       <= '{allow: allow_q, ram: cur_ram, burst: burst_q,
                                            addr: cur_addr, data: shift_nxt};
                            if (burst_q) cur_addr <= addr_adv;
                            else         phase_q  <= PH_DONE;
                        end
                    end
                    PH_RDATA: begin
                        if (bit_cnt == BIT_LAST) begin
                            if (burst_q) cur_addr <= addr_adv;
                            load_cnt <= CNT_LOAD;
                        end
                    end
                    default: ;
                endcase
            end else if (sclk_fall && phase_q == PH_RDATA) begin
                oe_q  <= 1'b1;
                sdo_q <= tx_q[bit_cnt];
            end
        end
    end
endmodule

// File: rtl/tw_reg_bank.sv
// Register side: control and charger registers, clock burst staging
// buffer with ordered commit, write strobes and the read data mux.
// Assumes a new write request never arrives during a burst commit.
module tw_reg_bank
    import tw_pkg::*;
#(
    parameter int BURST_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wreq_valid,
    input  tw_wreq_t          wreq,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              cur_ram,
    input  logic [DATA_W-1:0] clk_rdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              clk_wr_o,
    output logic              ram_wr_o,
    output logic              wp_o,
    output logic              trickle_en_o
);
    localparam int IDX_W = $clog2(BURST_LEN);
    localparam logic [ADDR_W-1:0] BURST_TOP = ADDR_W'(BURST_LEN - 1);
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(BURST_LEN - 1);

    logic [DATA_W-1:0] stage_q [BURST_LEN];
    logic              commit_act;
    logic [IDX_W-1:0]  commit_idx;
    logic              wp_q;
    logic [DATA_W-1:0] charge_q;
    logic              w_go, w_ram;
    logic [ADDR_W-1:0] w_addr;
    logic [DATA_W-1:0] w_data;
    logic              stage_wr;

    // Choose the write that lands this cycle: a commit step or a direct request.
    always_comb begin
        stage_wr = wreq_valid && wreq.allow && !wreq.ram && wreq.burst;
        w_go     = 1'b0;
        w_ram    = 1'b0;
        w_addr   = cur_addr;
        w_data   = '0;
        if (commit_act) begin
            w_go   = 1'b1;
            w_addr = ADDR_W'(commit_idx);
            w_data = stage_q[commit_idx];
        end else if (wreq_valid) begin
            w_go   = wreq.allow && !stage_wr;
            w_ram  = wreq.ram;
            w_addr = wreq.addr;
            w_data = wreq.data;
        end
    end

    // Staging buffer slots, one per clock burst location.
    for (genvar g = 0; g < BURST_LEN; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= '0;
            else if (stage_wr && wreq.addr == ADDR_W'(g)) stage_q[g] <= wreq.data;
        end
    end

    // Commit sequencer, protected registers and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_act  <= 1'b0;
            commit_idx  <= '0;
            wp_q        <= 1'b0;
            charge_q    <= '0;
            reg_addr_o  <= '0;
            reg_wdata_o <= '0;
            clk_wr_o    <= 1'b0;
            ram_wr_o    <= 1'b0;
        end else begin
            clk_wr_o    <= 1'b0;
            ram_wr_o    <= 1'b0;
            reg_addr_o  <= w_addr;
            reg_wdata_o <= w_data;
            if (commit_act) begin
                commit_idx <= commit_idx + 1'b1;
                if (commit_idx == IDX_LAST) commit_act <= 1'b0;
            end else if (stage_wr && wreq.addr == BURST_TOP) begin
                commit_act <= 1'b1;
                commit_idx <= '0;
            end
            if (w_go) begin
                if (w_ram) begin
                    if (w_addr != LOC_BURST && !wp_q) ram_wr_o <= 1'b1;
                end else if (w_addr < LOC_CTRL) begin
                    if (!wp_q) clk_wr_o <= 1'b1;
                end else if (w_addr == LOC_CTRL) begin
                    wp_q <= w_data[DATA_W-1];
                end else if (w_addr == LOC_CHARGE) begin
                    if (!wp_q) charge_q <= w_data;
                end
            end
        end
    end

    // Read data for the presented location; empty slots read zero.
    always_comb begin
        if (cur_ram)                       rd_data = (reg_addr_o == LOC_BURST) ? '0 : ram_rdata;
        else if (reg_addr_o < LOC_CTRL)    rd_data = clk_rdata;
        else if (reg_addr_o == LOC_CTRL)   rd_data = {wp_q, {(DATA_W-1){1'b0}}};
        else if (reg_addr_o == LOC_CHARGE) rd_data = charge_q;
        else                               rd_data = '0;
    end

    assign wp_o         = wp_q;
    assign trickle_en_o = (charge_q[DATA_W-1:DATA_W-4] == 4'b1010);
endmodule

// File: rtl/triwire_slave.sv
// Top of the three-wire serial register slave: synchronizes the host
// pins, detects serial clock edges and joins the protocol engine to the
// register side. Assumes the host holds each serial level for at least
// 8 system cycles. The output enable is also gated by the raw enable pin
// so the line is released without synchronizer delay.
module triwire_slave
    import tw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOAD_WAIT   = 3,
    parameter int BURST_LEN   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_i,
    input  logic              sclk_i,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              clk_wr_o,
    output logic              ram_wr_o,
    input  logic [DATA_W-1:0] clk_rdata_i,
    input  logic [DATA_W-1:0] ram_rdata_i,
    output logic              wp_o,
    output logic              trickle_en_o
);
    logic [2:0]        pins_s;
    logic              sclk_d, sclk_rise, sclk_fall, oe_q;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_ram, wreq_valid;
    tw_wreq_t          wreq;
    logic [DATA_W-1:0] rd_data;

    tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({sdio_i, sclk_i, ce_i}), .sync_o(pins_s)
    );

    // Delay the synchronized serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= pins_s[1];
    end

    assign sclk_rise = pins_s[1] & ~sclk_d;
    assign sclk_fall = ~pins_s[1] & sclk_d;

    tw_serial_fsm #(.LOAD_WAIT(LOAD_WAIT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ce_s(pins_s[0]), .sdi_s(pins_s[2]),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .rd_data(rd_data),
        .cur_addr(cur_addr), .cur_ram(cur_ram), .wreq(wreq),
        .wreq_valid(wreq_valid), .sdo_q(sdio_o), .oe_q(oe_q)
    );

    tw_reg_bank #(.BURST_LEN(BURST_LEN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wreq_valid(wreq_valid), .wreq(wreq),
        .cur_addr(cur_addr), .cur_ram(cur_ram), .clk_rdata(clk_rdata_i),
        .ram_rdata(ram_rdata_i), .rd_data(rd_data), .reg_addr_o(reg_addr_o),
        .reg_wdata_o(reg_wdata_o), .clk_wr_o(clk_wr_o), .ram_wr_o(ram_wr_o),
        .wp_o(wp_o), .trickle_en_o(trickle_en_o)
    );

    assign sdio_oe = oe_q & ce_i;
endmodule

// File: rtl/triwire_slave_chk.sv
// Protocol and register-side properties of the serial slave, bound to
// the top module. Assumes the synchronous active-low reset of the top.
module triwire_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sclk_rise,
    input logic       sdio_oe,
    input logic       clk_wr_o,
    input logic       ram_wr_o,
    input logic       wp_o,
    input logic [4:0] reg_addr_o
);
    // R3: only one target is written at a time
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clk_wr_o, ram_wr_o}));

    // R10: no strobe leaves while write protect was set
    a_r10_protect: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_wr_o || ram_wr_o) |-> !$past(wp_o));

    // R11: RAM slot 31 is never written
    a_r11_ram_empty: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_o |-> reg_addr_o != 5'd31);

    // R11: clock file strobes only for its seven locations
    a_r11_clk_range: assert property (@(posedge clk) disable iff (!rst_n)
        clk_wr_o |-> reg_addr_o < 5'd7);

    // R13: the line is released after each rising serial edge
    a_r13_release: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> !sdio_oe);
endmodule

bind triwire_slave triwire_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sdio_oe(sdio_oe),
    .clk_wr_o(clk_wr_o), .ram_wr_o(ram_wr_o), .wp_o(wp_o),
    .reg_addr_o(reg_addr_o)
);

// File: tb/triwire_slave_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected write strobes, a monitor
// pops and compares them; read bytes and outputs are checked inline.
module triwire_slave_tb_top;
    localparam int H = 100;  // serial half period in ns

    typedef struct {
        bit         ram;
        logic [4:0] addr;
        logic [7:0] data;
        string      req;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_i = 1'b0, sclk_i = 1'b0, sdio_i = 1'b0;
    logic sdio_o, sdio_oe, clk_wr_o, ram_wr_o, wp_o, trickle_en_o;
    logic [4:0] reg_addr_o;
    logic [7:0] reg_wdata_o, clk_rdata_i, ram_rdata_i;
    logic [7:0] cf_m [7];
    logic [7:0] ram_m [31];
    exp_t q [$];
    int n_chk = 0, n_err = 0, clk_cnt = 0, ram_cnt = 0;

    always #2.5 clk = ~clk;

    triwire_slave dut_i (
        .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .sclk_i(sclk_i), .sdio_i(sdio_i),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .reg_addr_o(reg_addr_o),
        .reg_wdata_o(reg_wdata_o), .clk_wr_o(clk_wr_o), .ram_wr_o(ram_wr_o),
        .clk_rdata_i(clk_rdata_i), .ram_rdata_i(ram_rdata_i), .wp_o(wp_o),
        .trickle_en_o(trickle_en_o)
    );

    // External clock file and RAM models; 0xEE marks locations they lack.
    always_comb begin
        clk_rdata_i = (reg_addr_o < 5'd7) ? cf_m[reg_addr_o[2:0]] : 8'hEE;
        ram_rdata_i = (reg_addr_o != 5'd31) ? ram_m[reg_addr_o] : 8'hEE;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: update models and compare every strobe with the queue head.
    always @(negedge clk) begin
        if (rst_n && (clk_wr_o || ram_wr_o)) begin
            exp_t e;
            if (ram_wr_o) begin
                ram_cnt++;
                if (reg_addr_o != 5'd31) ram_m[reg_addr_o] = reg_wdata_o;
            end else begin
                clk_cnt++;
                if (reg_addr_o < 5'd7) cf_m[reg_addr_o[2:0]] = reg_wdata_o;
            end
            if (q.size() == 0) begin
                check(1'b0, "R3 unexpected strobe", {18'd0, ram_wr_o, reg_addr_o, reg_wdata_o}, 0);
            end else begin
                e = q.pop_front();
                check({ram_wr_o, reg_addr_o, reg_wdata_o} == {e.ram, e.addr, e.data}, e.req,
                      {18'd0, ram_wr_o, reg_addr_o, reg_wdata_o}, {18'd0, e.ram, e.addr, e.data});
            end
        end
    end

    task automatic expect_wr(input bit ram, input logic [4:0] a, input logic [7:0] d,
                             input string req);
        q.push_back('{ram: ram, addr: a, data: d, req: req});
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sdio_i = b[i];
            #(H) sclk_i = 1'b1;
            #(H) sclk_i = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic recv_byte(output logic [7:0] b);
        bit oe_ok = 1'b1, rel_ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            #(H - 10) b[i] = sdio_o;
            oe_ok &= (sdio_oe === 1'b1);
            #10 sclk_i = 1'b1;
            #30 rel_ok &= (sdio_oe === 1'b0);
            #(H - 30) sclk_i = 1'b0;
        end
        check(oe_ok, "R5 line driven during read bits", 32'(oe_ok), 1);
        check(rel_ok, "R13 line released after rising edge", 32'(rel_ok), 1);
    endtask

    task automatic xfer_begin();
        ce_i = 1'b1;
        #(H);
    endtask

    task automatic xfer_end();
        ce_i = 1'b0;
        #(3 * H);
    endtask

    task automatic wr1(input logic [7:0] cmd, input logic [7:0] d);
        xfer_begin();
        send_byte(cmd);
        send_byte(d);
        xfer_end();
    endtask

    task automatic rd1(input logic [7:0] cmd, output logic [7:0] d);
        xfer_begin();
        send_byte(cmd);
        recv_byte(d);
        xfer_end();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #900us;
        check(1'b0, "R1 watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] b, b2;
        int c0;
        for (int i = 0; i < 7; i++) cf_m[i] = 8'h30 + 8'(i);
        for (int i = 0; i < 31; i++) ram_m[i] = 8'h00;
        #50 rst_n = 1'b1;
        #20;
        // R1: reset state
        check(sdio_oe == 1'b0, "R1 oe after reset", 32'(sdio_oe), 0);
        check(wp_o == 1'b0, "R1 wp after reset", 32'(wp_o), 0);
        check(trickle_en_o == 1'b0, "R1 charger after reset", 32'(trickle_en_o), 0);
        check(clk_cnt + ram_cnt == 0, "R1 no strobe after reset", 32'(clk_cnt + ram_cnt), 0);

        // R2 R3: single write, clock location 3, command 0x86
        expect_wr(0, 5'd3, 8'h45, "R3 single write");
        wr1(8'h86, 8'h45);
        check(clk_cnt == 1, "R3 one strobe", 32'(clk_cnt), 1);

        // R5 R2: single read with extra cycles repeating the byte
        xfer_begin();
        send_byte(8'h87);
        recv_byte(b);
        recv_byte(b2);
        xfer_end();
        check(b == 8'h45, "R2 read back LSB first", 32'(b), 32'h45);
        check(b2 == 8'h45, "R5 extra cycles repeat byte", 32'(b2), 32'h45);

        // R5: extra cycles after a single write are ignored
        expect_wr(0, 5'd4, 8'h5A, "R5 write then extra cycles");
        xfer_begin();
        send_byte(8'h88);
        send_byte(8'h5A);
        send_byte(8'hFF);
        xfer_end();
        check(clk_cnt == 2, "R5 extra write cycles ignored", 32'(clk_cnt), 2);

        // R4: command bit 7 clear, write to location 2 discarded
        wr1(8'h04, 8'h77);
        check(clk_cnt == 2, "R4 no strobe without bit 7", 32'(clk_cnt), 2);
        rd1(8'h85, b);
        check(b == 8'h32, "R4 location 2 unchanged", 32'(b), 32'h32);

        // R7: RAM burst commits per byte
        expect_wr(1, 5'd0, 8'h11, "R7 RAM burst byte 0");
        expect_wr(1, 5'd1, 8'h22, "R7 RAM burst byte 1");
        expect_wr(1, 5'd2, 8'h33, "R7 RAM burst byte 2");
        xfer_begin();
        send_byte(8'hFE);
        send_byte(8'h11);
        #(2 * H);
        check(ram_cnt == 1, "R7 first byte committed early", 32'(ram_cnt), 1);
        send_byte(8'h22);
        send_byte(8'h33);
        xfer_end();
        check(ram_cnt == 3, "R7 three RAM strobes", 32'(ram_cnt), 3);

        // R6: clock burst write commits only after the eighth byte
        for (int i = 0; i < 7; i++) expect_wr(0, 5'(i), 8'h10 + 8'(i), "R6 burst commit order");
        xfer_begin();
        send_byte(8'hBE);
        for (int i = 0; i < 7; i++) send_byte(8'h10 + 8'(i));
        #(2 * H);
        check(clk_cnt == 2, "R6 nothing before eighth byte", 32'(clk_cnt), 2);
        send_byte(8'h00);
        #(2 * H);
        check(clk_cnt == 9, "R6 seven clock strobes after eighth", 32'(clk_cnt), 9);
        xfer_end();

        // R8 R11: clock burst read from location 0 through 9
        xfer_begin();
        send_byte(8'hBF);
        for (int i = 0; i < 10; i++) begin
            logic [7:0] exp_b;
            recv_byte(b);
            exp_b = (i < 7) ? 8'h10 + 8'(i) : 8'h00;
            check(b == exp_b, (i == 9) ? "R11 empty location reads 0" : "R8 burst read",
                  32'(b), 32'(exp_b));
        end
        xfer_end();

        // R9: charger select decode and read back
        wr1(8'h90, 8'hA5);
        check(trickle_en_o == 1'b1, "R9 pattern 1010 enables", 32'(trickle_en_o), 1);
        rd1(8'h91, b);
        check(b == 8'hA5, "R9 full byte read back", 32'(b), 32'hA5);
        wr1(8'h90, 8'hB5);
        check(trickle_en_o == 1'b0, "R9 pattern 1011 disables", 32'(trickle_en_o), 0);
        wr1(8'h90, 8'hA0);
        check(trickle_en_o == 1'b1, "R9 pattern 1010 low nibble 0", 32'(trickle_en_o), 1);

        // R10: write protect blocks other registers
        wr1(8'h8E, 8'hFF);
        check(wp_o == 1'b1, "R10 protect set", 32'(wp_o), 1);
        rd1(8'h8F, b);
        check(b == 8'h80, "R10 control low bits read 0", 32'(b), 32'h80);
        c0 = clk_cnt + ram_cnt;
        wr1(8'h82, 8'h99);
        wr1(8'hCA, 8'h99);
        wr1(8'h90, 8'h00);
        check(clk_cnt + ram_cnt == c0, "R10 protected writes dropped", 32'(clk_cnt + ram_cnt), 32'(c0));
        check(trickle_en_o == 1'b1, "R10 charger kept", 32'(trickle_en_o), 1);
        wr1(8'h8E, 8'h00);
        check(wp_o == 1'b0, "R10 protect cleared", 32'(wp_o), 0);

        // R11: empty clock location reads 0 and takes no write
        rd1(8'h99, b);
        check(b == 8'h00, "R11 clock location 12 reads 0", 32'(b), 0);
        wr1(8'hA8, 8'h55);
        check(clk_cnt == 9, "R11 write to location 20 dropped", 32'(clk_cnt), 9);
        rd1(8'hC1, b);
        check(b == 8'h11, "R7 RAM location 0 holds burst byte", 32'(b), 32'h11);

        // R12: enable low mid-read releases the line at once
        xfer_begin();
        send_byte(8'h87);
        #(H - 10);
        check(sdio_oe == 1'b1, "R12 driving before abort", 32'(sdio_oe), 1);
        ce_i = 1'b0;
        #1;
        check(sdio_oe == 1'b0, "R12 released on enable low", 32'(sdio_oe), 0);
        #(3 * H);
        // R12: partial write byte discarded, next transfer decodes fresh
        xfer_begin();
        send_byte(8'h84);
        send_bits(8'hFF, 4);
        xfer_end();
        check(clk_cnt == 9, "R12 partial byte discarded", 32'(clk_cnt), 9);
        expect_wr(0, 5'd2, 8'h66, "R12 fresh transfer after abort");
        wr1(8'h84, 8'h66);
        check(clk_cnt == 10, "R12 next transfer works", 32'(clk_cnt), 10);

        check(q.size() == 0, "R3 all expected strobes seen", 32'(q.size()), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule